// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block turns two reset causes into a clean processor reset. One cause is a supply-good flag that an external voltage comparator produces. The other is a manual reset input, active low, that is typically wired to a pushbutton. Both inputs are asynchronous to the block's clock, so each one passes through its own synchronizer before any logic uses it. While either cause is present, the reset outputs stay asserted. Once every cause has gone away, the reset is held for a further interval of `HOLD_CYCLES` clock cycles. The integrator derives that count from the clock frequency and the wanted hold time. A nominal setting is 200 ms, and no setting should be below 140 ms.

The hold counter reloads on every cycle in which a cause is active, and it counts down only when no cause is active. A bouncing pushbutton therefore produces one long reset pulse, not a burst of short ones, and no separate debouncer is needed. A brownout that arrives during a hold restarts the full interval. The block drives the reset at both polarities from two separate registers. A status output shows when the hold interval is counting down.

Top module: `supv_reset_gen`

## Requirements
- R1: While the synchronous reset `rst_n` is low, `rst_n_o` is 0, `rst_o` is 1 and `hold_busy_o` is 0. With both inputs high when `rst_n` is released, `rst_n_o` rises on the (HOLD_CYCLES+3)th clock edge after `rst_n` goes high.
- R2: When `supply_ok_i` goes low, `rst_n_o` falls on the 3rd clock edge after the change. It stays low for as long as `supply_ok_i` stays low.
- R3: After `supply_ok_i` returns high, with `mrst_n_i` high, `rst_n_o` stays low and rises on the (HOLD_CYCLES+3)th clock edge after the change.
- R4: A low level on `mrst_n_i` drives `rst_n_o` low on the 3rd clock edge after the change.
- R5: After `mrst_n_i` returns high, with the supply good, `rst_n_o` rises on the (HOLD_CYCLES+3)th clock edge after that change.
- R6: A cause that reappears during the hold interval restarts the interval. A manual input that bounces for longer than the interval gives one unbroken low pulse on `rst_n_o`, which ends HOLD_CYCLES+3 edges after the last rising edge of the input.
- R7: A brownout (`supply_ok_i` low) that begins during a hold interval keeps `rst_n_o` low. Release then comes HOLD_CYCLES+3 edges after `supply_ok_i` returns high.
- R8: `rst_o` equals the inverse of `rst_n_o` on every cycle.
- R9: `hold_busy_o` is 1 exactly while the hold interval counts down with no cause present. After a cause clears, it is high for HOLD_CYCLES consecutive cycles, starting after the 2nd edge, and `rst_n_o` is low whenever it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok_i | input | 1 | Asynchronous supply-good flag from the comparator; 1 = supply above threshold |
| mrst_n_i | input | 1 | Asynchronous manual reset request, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| hold_busy_o | output | 1 | High while the post-cause hold interval counts down |

## Verification
The bound checker checks the per-cycle relations on every clock edge: the two outputs are always complementary, a visible cause forces reset on the next edge, a counting interval always coincides with an asserted reset, and reset releases only on the edge after the countdown ends. Only the bench scenarios can show the exact latencies from input pins to outputs through the synchronizers. The same holds for the full length of the hold interval after each kind of cause, the single pulse produced by a bouncing button, and the restart of the interval by a brownout that arrives mid-hold.

// File: rtl/supv_pkg.sv
// Package: shared types and helpers for the supervisor reset generator.
// Assumes: both cause flags are already synchronized when packed into cause_t.
package supv_pkg;

    // Default depth of the input synchronizers.
    localparam int SYNC_STAGES_DEF = 2;

    // One bit per reset cause, each set while that cause is active.
    typedef struct packed {
        logic supply_low;
        logic manual_press;
    } cause_t;

    // True when at least one cause is present.
    function automatic logic any_cause(input cause_t c);
        return c.supply_low | c.manual_press;
    endfunction

endpackage

// File: rtl/supv_sync.sv
// Module: multi-bit, multi-stage level synchronizer.
// Does: carries each bit of din through STAGES flops into the clk domain.
// Assumes: each bit is a slow level; bits are not treated as one coherent word.
module supv_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= {WIDTH{RST_VAL}};
                else        stg[s] <= din;
            end
        end else begin : g_next
            // Later stages let any metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= {WIDTH{RST_VAL}};
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/supv_hold_timer.sv
// Module: reset hold-interval counter.
// Does: reloads to HOLD_CYCLES on every cycle that a cause is present and counts
//       down to zero once none is. Asks for reset while a cause or a count remains.
// Assumes: the cause flags are synchronous to clk; HOLD_CYCLES >= 1.
module supv_hold_timer
    import supv_pkg::*;
#(
    parameter int HOLD_CYCLES = 20
) (
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t cause,
    output logic   want_reset,
    output logic   counting
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             cause_now;
    logic             cnt_nz;

    // Fold the cause bits into one request.
    always_comb cause_now = any_cause(cause);

    // Flag a remaining hold count.
    always_comb cnt_nz = (cnt_q != '0);

    // Reload on a cause or on power-on reset; otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= RELOAD;
        else if (cause_now) cnt_q <= RELOAD;
        else if (cnt_nz)    cnt_q <= cnt_q - 1'b1;
    end

    // Reset is wanted while a cause or a hold count remains.
    always_comb want_reset = cause_now | cnt_nz;

    // The interval counts only when no cause holds it at the reload value.
    always_comb counting = cnt_nz & ~cause_now;
endmodule

// File: rtl/supv_out_stage.sv
// Module: output registers for the two reset polarities.
// Does: registers the reset request into one active-low and one active-high flop.
// Assumes: want_reset is synchronous to clk; both flops come up asserted.
module supv_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic want_reset,
    output logic rst_low,
    output logic rst_high
);
    // Active-low reset output register.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_low <= 1'b0;
        else        rst_low <= ~want_reset;
    end

    // Active-high reset output register, a separate flop on the same request.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_high <= 1'b1;
        else        rst_high <= want_reset;
    end
endmodule

// File: rtl/supv_reset_gen.sv
// Module: supervisor reset pulse generator (top).
// Does: synchronizes the supply-good flag and the manual reset input, holds
//       reset for HOLD_CYCLES after the last cause clears, and drives reset at
//       both polarities plus a hold-in-progress status.
// Assumes: rst_n is the chip's internal power-on reset, synchronous to clk.
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int HOLD_CYCLES = 20,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic mrst_n_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic hold_busy_o
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] sync_in;
    cause_t            cause;
    logic              cause_any;
    logic              want_reset;
    logic              counting;

    // Gather the asynchronous inputs into one vector; bit 1 is supply, bit 0 is manual.
    always_comb raw_in = {supply_ok_i, mrst_n_i};

    supv_sync #(
        .WIDTH   (NUM_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_in)
    );

    // Turn the synchronized levels into active-high causes.
    always_comb begin
        cause.supply_low   = ~sync_in[1];
        cause.manual_press = ~sync_in[0];
    end

    // Combined cause, also watched by the checker.
    always_comb cause_any = any_cause(cause);

    supv_hold_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause     (cause),
        .want_reset(want_reset),
        .counting  (counting)
    );

    supv_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_reset(want_reset),
        .rst_low   (rst_n_o),
        .rst_high  (rst_o)
    );

    // Status output: hold interval counting down.
    always_comb hold_busy_o = counting;
endmodule

// File: rtl/supv_reset_gen_chk.sv
// Module: per-cycle property checker for supv_reset_gen, attached by bind.
// Assumes: sees the top's ports and its combined, synchronized cause.
module supv_reset_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic rst_n_o,
    input logic rst_o,
    input logic hold_busy_o,
    input logic cause_any
);
    // R8
    polarity_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o == !rst_n_o);

    // R2 R4
    cause_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_any |=> !rst_n_o);

    // R9
    busy_means_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_busy_o |-> !rst_n_o);

    // R3 R5
    release_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_o) |-> ($past(hold_busy_o, 2) && !$past(cause_any)));

    // R9
    end_of_hold_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_busy_o) && !cause_any) |=> rst_n_o);
endmodule

bind supv_reset_gen supv_reset_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_o    (rst_n_o),
    .rst_o      (rst_o),
    .hold_busy_o(hold_busy_o),
    .cause_any  (cause_any)
);

// File: tb/supv_reset_gen_test.sv
module supv_reset_gen_test;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok_i = 1'b1;
    logic mrst_n_i = 1'b1;
    logic rst_n_o, rst_o, hold_busy_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    supv_reset_gen #(.HOLD_CYCLES(H)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i), .mrst_n_i(mrst_n_i),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .hold_busy_o(hold_busy_o)
    );

    typedef struct packed {
        logic       sup;
        logic       mr;
        logic [7:0] cyc;
        logic       exp_rn;
        logic       exp_busy;
        logic [3:0] req;
    } vec_t;

    // Each row: drive inputs, wait cyc edges, then expect rst_n_o / hold_busy_o.
    localparam vec_t VECS [11] = '{
        '{1'b1, 1'b1, 8'd5,       1'b1, 1'b0, 4'd8},  // R8 idle
        '{1'b0, 1'b1, 8'd2,       1'b1, 1'b0, 4'd2},  // R2 still in sync
        '{1'b0, 1'b1, 8'd1,       1'b0, 1'b0, 4'd2},  // R2 edge 3
        '{1'b0, 1'b1, 8'd30,      1'b0, 1'b0, 4'd2},  // R2 held
        '{1'b1, 1'b1, 8'd3,       1'b0, 1'b1, 4'd9},  // R9 counting
        '{1'b1, 1'b1, 8'(H - 2),  1'b0, 1'b1, 4'd3},  // R3 edge H+1
        '{1'b1, 1'b1, 8'd1,       1'b0, 1'b0, 4'd3},  // R3 edge H+2
        '{1'b1, 1'b1, 8'd1,       1'b1, 1'b0, 4'd3},  // R3 edge H+3
        '{1'b1, 1'b0, 8'd3,       1'b0, 1'b0, 4'd4},  // R4 edge 3
        '{1'b1, 1'b1, 8'(H + 2),  1'b0, 1'b0, 4'd5},  // R5 edge H+2
        '{1'b1, 1'b1, 8'd1,       1'b1, 1'b0, 4'd5}   // R5 edge H+3
    };

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Counts edges until rst_n_o goes high; rst_n_o must stay low meanwhile.
    task automatic edges_to_release(input string req, output int n, output bit dropped);
        n = 0;
        dropped = 1'b0;
        while (rst_n_o == 1'b0 && n < 1000) begin
            if (rst_o !== 1'b1) dropped = 1'b1;
            edges(1);
            n++;
        end
        check(req, "rst_o inverse at release", int'(rst_o), int'(!rst_n_o));
    endtask

    initial begin
        int n;
        bit dr;
        bit went_high;
        edges(3);
        // R1 reset state
        check("R1", "rst_n_o in reset", int'(rst_n_o), 0);
        check("R1", "rst_o in reset", int'(rst_o), 1);
        check("R1", "hold_busy_o in reset", int'(hold_busy_o), 0);
        rst_n = 1'b1;
        edges_to_release("R1", n, dr);
        check("R1", "edges to release after power-on", n, H + 3);

        // Table walk
        foreach (VECS[i]) begin
            supply_ok_i = VECS[i].sup;
            mrst_n_i = VECS[i].mr;
            edges(int'(VECS[i].cyc));
            check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d rst_n_o", i),
                  int'(rst_n_o), int'(VECS[i].exp_rn));
            check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d hold_busy_o", i),
                  int'(hold_busy_o), int'(VECS[i].exp_busy));
            check("R8", $sformatf("row %0d rst_o", i), int'(rst_o), int'(!rst_n_o));
        end

        // R9: count busy cycles after a manual press
        mrst_n_i = 1'b0;
        edges(5);
        mrst_n_i = 1'b1;
        n = 0;
        for (int i = 0; i < H + 6; i++) begin
            edges(1);
            if (hold_busy_o) n++;
        end
        check("R9", "busy cycle count", n, H);
        check("R9", "released after count", int'(rst_n_o), 1);

        // R6: bouncing button, one unbroken pulse
        mrst_n_i = 1'b0;
        edges(3);
        went_high = 1'b0;
        for (int k = 0; k < 12; k++) begin
            mrst_n_i = 1'b1;
            edges(3);
            if (rst_n_o) went_high = 1'b1;
            mrst_n_i = 1'b0;
            edges(2);
            if (rst_n_o) went_high = 1'b1;
        end
        check("R6", "pulse broke during bounce", int'(went_high), 0);
        mrst_n_i = 1'b1;
        edges_to_release("R6", n, dr);
        check("R6", "edges from last rise to release", n, H + 3);
        check("R6", "rst_o dropped during hold", int'(dr), 0);

        // R7: brownout during hold extends the pulse
        edges(4);
        mrst_n_i = 1'b0;
        edges(4);
        mrst_n_i = 1'b1;
        edges(8);
        check("R7", "still held mid-interval", int'(rst_n_o), 0);
        supply_ok_i = 1'b0;
        edges(4);
        check("R7", "held during brownout", int'(rst_n_o), 0);
        supply_ok_i = 1'b1;
        edges_to_release("R7", n, dr);
        check("R7", "edges from supply return to release", n, H + 3);

        // R1: mid-run power-on reset re-asserts outputs
        rst_n = 1'b0;
        edges(1);
        check("R1", "rst_n_o on re-reset", int'(rst_n_o), 0);
        check("R1", "rst_o on re-reset", int'(rst_o), 1);
        rst_n = 1'b1;
        edges_to_release("R1", n, dr);
        check("R1", "edges to release after re-reset", n, H + 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule